// File: doc/BRIEF.md
# Normalising Barrel Shifter

This block shifts a 16-bit word under a 4-bit opcode that selects among sixteen operations: logical shifts in both directions, rotates in both directions, arithmetic right shifts, pass-through with loading of a shift-amount register, and normalisation. The opcode, the data word and the external shift amount are all captured on the same rising clock edge. The result is valid for the whole of the following cycle.

The shift amount comes from one of four places. It can be the registered external amount, one of two programmable 4-bit amount registers (first and second), or a leading-sign counter. The counter finds how far a word must move left so that its top two bits differ. The normalise opcodes drive that count back out on the shift-amount port when the port enable is low. Two of them also save the count in an amount register, so a later opcode can apply the same scaling to other words.

Top module: `norm_shifter`

## Requirements
- R1: Opcodes 0 and 1 shift the captured word right (0) or left (1), filling vacated bits with zeros. The amount is the unsigned 4-bit svIn value captured on the same edge as the opcode, and 0 means no shift.
- R2: Opcodes 2 and 3 rotate the word right (2) or left (3) by the captured svIn amount, so bits leaving one end re-enter at the other.
- R3: Opcodes A, B and C shift right and fill vacated bits with copies of the original bit 15. The amount comes from svIn (A), the first amount register (B) or the second amount register (C).
- R4: Opcodes 4 and 5 shift right/left with zero fill by the first amount register. Opcodes 6 and 7 do the same by the second amount register.
- R5: Opcode 8 loads the first amount register from the captured svIn, and opcode 9 loads the second. The load takes effect at the edge that ends the cycle, so the next opcode sees the new value. While 8 or 9 executes, the result equals the word unshifted.
- R6: Opcodes D, E and F shift the word left by a count, filling with zeros. The count is the number of consecutive bits directly below bit 15 that equal bit 15, with a maximum of 15. An all-zero or all-one word therefore gives 15. For any other word, bits 15 and 14 of the result differ.
- R7: Opcode E also loads the count into the first amount register at the end of the cycle, and opcode F loads it into the second. Opcode D loads neither.
- R8: svOutEn is 1 only while D, E or F executes and svOeN is low. svOut then carries the count. At all other times svOutEn is 0 and svOut is 0.
- R9: clr held high across a rising edge sets both amount registers, the captured opcode, the captured word and the captured amount to zero. The result in the following cycle is 0.
- R10: Any opcode other than 8, 9, E and F leaves both amount registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr | input | 1 | Synchronous clear, active high |
| dataIn | input | 16 | Word to shift, captured each edge |
| instr | input | 4 | Opcode, captured each edge |
| svIn | input | 4 | External shift amount, captured each edge |
| svOeN | input | 1 | Active-low permission for the block to drive the amount port |
| result | output | 16 | Shifted word for the opcode in execution |
| svOut | output | 4 | Leading-sign count during normalise opcodes |
| svOutEn | output | 1 | High when svOut should drive the amount port |

## Verification
The bench runs the encoder on all-zero and all-one words, on single set bits at each end, and on words whose top two bits already differ. An encoder that counted past bit 0 or stopped one early would leave the top two result bits equal or would push a significant bit out. An opcode that reads an amount register straight after opcode 8 or E catches a load landing a cycle late or early, since the first shift would then use the stale amount. Rotates and arithmetic shifts by 15 and by 0 expose wrong fill or wrap-around. Toggling svOeN during normalise shows whether the port is driven without permission.

// File: rtl/shiftPkg.sv
package shiftPkg;
  localparam int DATA_W = 16;
  localparam int AMT_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    K_LSR, K_LSL, K_ROR, K_ROL, K_ASR, K_PASS, K_NORM
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [AMT_W-1:0] amt;
  } strobe_t;
endpackage

// File: rtl/shiftCtrl.sv
module shiftCtrl
  import shiftPkg::*;
(
  input  logic             clk,
  input  logic             clr,
  input  logic [3:0]       instr,
  input  logic [AMT_W-1:0] svIn,
  input  logic             svOeN,
  input  logic [AMT_W-1:0] normCount,
  output strobe_t          strobe,
  output logic [AMT_W-1:0] svOut,
  output logic             svOutEn
);
  logic [3:0]       instrQ;
  logic [AMT_W-1:0] svQ, regOne, regTwo;
  logic             isNorm;

  always_ff @(posedge clk) begin
    if (clr) begin
      instrQ <= '0;
      svQ    <= '0;
      regOne <= '0;
      regTwo <= '0;
    end else begin
      instrQ <= instr;
      svQ    <= svIn;
      case (instrQ)
        4'h8: regOne <= svQ;
        4'h9: regTwo <= svQ;
        4'hE: regOne <= normCount;
        4'hF: regTwo <= normCount;
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.amt  = svQ;
    strobe.kind = K_PASS;
    case (instrQ)
      4'h0: strobe.kind = K_LSR;
      4'h1: strobe.kind = K_LSL;
      4'h2: strobe.kind = K_ROR;
      4'h3: strobe.kind = K_ROL;
      4'h4: begin strobe.kind = K_LSR; strobe.amt = regOne; end
      4'h5: begin strobe.kind = K_LSL; strobe.amt = regOne; end
      4'h6: begin strobe.kind = K_LSR; strobe.amt = regTwo; end
      4'h7: begin strobe.kind = K_LSL; strobe.amt = regTwo; end
      4'hA: strobe.kind = K_ASR;
      4'hB: begin strobe.kind = K_ASR; strobe.amt = regOne; end
      4'hC: begin strobe.kind = K_ASR; strobe.amt = regTwo; end
      4'hD, 4'hE, 4'hF: strobe.kind = K_NORM;
      default: strobe.kind = K_PASS;
    endcase
  end

  assign isNorm  = (strobe.kind == K_NORM);
  assign svOutEn = isNorm && !svOeN;
  assign svOut   = svOutEn ? normCount : '0;

  // R5: opcode 8 loads the first amount register from the captured amount
  p_load_one_r5: assert property (@(posedge clk) disable iff (clr)
    instrQ == 4'h8 |=> regOne == $past(svQ));
  // R7: opcode F saves the encoder count in the second register
  p_norm_save_r7: assert property (@(posedge clk) disable iff (clr)
    instrQ == 4'hF |=> regTwo == $past(normCount));
  // R10: other opcodes hold the first register
  p_hold_one_r10: assert property (@(posedge clk) disable iff (clr)
    (instrQ != 4'h8 && instrQ != 4'hE) |=> $stable(regOne));
  p_hold_two_r10: assert property (@(posedge clk) disable iff (clr)
    (instrQ != 4'h9 && instrQ != 4'hF) |=> $stable(regTwo));
endmodule

// File: rtl/shiftData.sv
module shiftData
  import shiftPkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic [DATA_W-1:0] dataIn,
  input  strobe_t           strobe,
  output logic [DATA_W-1:0] result,
  output logic [AMT_W-1:0]  normCount
);
  logic [DATA_W-1:0]   dataQ;
  logic [2*DATA_W-1:0] dbl;
  logic [2*DATA_W-1:0] rotR, rotL;
  logic                runOn;

  always_ff @(posedge clk) begin
    if (clr) dataQ <= '0;
    else     dataQ <= dataIn;
  end

  always_comb begin
    normCount = '0;
    runOn     = 1'b1;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (runOn && dataQ[i] == dataQ[DATA_W-1]) normCount = normCount + AMT_W'(1);
      else runOn = 1'b0;
    end
  end

  assign dbl  = {dataQ, dataQ};
  assign rotR = dbl >> strobe.amt;
  assign rotL = dbl << strobe.amt;

  always_comb begin
    case (strobe.kind)
      K_LSR:   result = dataQ >> strobe.amt;
      K_LSL:   result = dataQ << strobe.amt;
      K_ROR:   result = rotR[DATA_W-1:0];
      K_ROL:   result = rotL[2*DATA_W-1:DATA_W];
      K_ASR:   result = $unsigned($signed(dataQ) >>> strobe.amt);
      K_NORM:  result = dataQ << normCount;
      default: result = dataQ;
    endcase
  end

  // R5: pass-through leaves the captured word untouched
  p_pass_r5: assert property (@(posedge clk) disable iff (clr)
    strobe.kind == K_PASS |-> result == dataQ);
  // R6: a normalised non-trivial word has differing top bits
  p_norm_top_r6: assert property (@(posedge clk) disable iff (clr)
    (strobe.kind == K_NORM && dataQ != '0 && dataQ != '1)
      |-> result[DATA_W-1] != result[DATA_W-2]);
endmodule

// File: rtl/norm_shifter.sv
module norm_shifter
  import shiftPkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [3:0]        instr,
  input  logic [AMT_W-1:0]  svIn,
  input  logic              svOeN,
  output logic [DATA_W-1:0] result,
  output logic [AMT_W-1:0]  svOut,
  output logic              svOutEn
);
  strobe_t          strobe;
  logic [AMT_W-1:0] normCount;

  shiftCtrl u_ctrl (
    .clk(clk), .clr(clr), .instr(instr), .svIn(svIn), .svOeN(svOeN),
    .normCount(normCount), .strobe(strobe), .svOut(svOut), .svOutEn(svOutEn)
  );

  shiftData u_data (
    .clk(clk), .clr(clr), .dataIn(dataIn), .strobe(strobe),
    .result(result), .normCount(normCount)
  );

  // R8: the port is never driven without permission
  p_sv_drive_r8: assert property (@(posedge clk) disable iff (clr)
    svOutEn |-> !svOeN);
endmodule

// File: tb/test_norm_shifter.sv
module test_norm_shifter;
  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic [15:0] dataIn = '0;
  logic [3:0]  instr = '0;
  logic [3:0]  svIn = '0;
  logic        svOeN = 1'b1;
  logic [15:0] result;
  logic [3:0]  svOut;
  logic        svOutEn;

  int checks = 0;
  int fails  = 0;
  logic [3:0] mOne = '0, mTwo = '0;

  norm_shifter i_norm_shifter (.*);

  always #4 clk = ~clk;

  function automatic logic [3:0] lead(input logic [15:0] d);
    logic [3:0] c = 0;
    for (int i = 14; i >= 0; i--) begin
      if (d[i] != d[15]) return c;
      c = c + 4'd1;
    end
    return c;
  endfunction

  function automatic logic [15:0] model(input logic [3:0] op, input logic [15:0] d,
                                        input logic [3:0] sv, input logic [3:0] a1,
                                        input logic [3:0] a2);
    logic [15:0] r = d;
    int n;
    case (op)
      4'h0, 4'h4, 4'h6: begin
        n = (op == 4'h0) ? sv : (op == 4'h4) ? a1 : a2;
        for (int k = 0; k < n; k++) r = {1'b0, r[15:1]};
      end
      4'h1, 4'h5, 4'h7: begin
        n = (op == 4'h1) ? sv : (op == 4'h5) ? a1 : a2;
        for (int k = 0; k < n; k++) r = {r[14:0], 1'b0};
      end
      4'h2: for (int k = 0; k < sv; k++) r = {r[0], r[15:1]};
      4'h3: for (int k = 0; k < sv; k++) r = {r[14:0], r[15]};
      4'hA, 4'hB, 4'hC: begin
        n = (op == 4'hA) ? sv : (op == 4'hB) ? a1 : a2;
        for (int k = 0; k < n; k++) r = {r[15], r[15:1]};
      end
      4'hD, 4'hE, 4'hF: for (int k = 0; k < lead(d); k++) r = {r[14:0], 1'b0};
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'h0, 4'h1: return "R1";
      4'h2, 4'h3: return "R2";
      4'hA, 4'hB, 4'hC: return "R3";
      4'h4, 4'h5, 4'h6, 4'h7: return "R4";
      4'h8, 4'h9: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [15:0] d, input logic [3:0] sv,
                      input logic oeN);
    logic [3:0] cnt;
    logic       drive;
    instr = op; dataIn = d; svIn = sv; svOeN = oeN;
    @(posedge clk);
    @(negedge clk);
    cnt   = lead(d);
    drive = (op >= 4'hD) && !oeN;
    chk(tag(op), result, model(op, d, sv, mOne, mTwo));
    chk("R8 en", {15'd0, svOutEn}, {15'd0, drive});
    chk("R8 val", {12'd0, svOut}, drive ? {12'd0, cnt} : 16'd0);
    case (op)
      4'h8: mOne = sv;
      4'h9: mTwo = sv;
      4'hE: mOne = cnt;
      4'hF: mTwo = cnt;
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0]  rop;
    logic [15:0] rd;
    void'($urandom(1601));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset", result, 16'h0000);
    clr = 1'b0;
    // R6 encoder corners
    step(4'hD, 16'h0000, 4'd0, 1'b0);
    step(4'hD, 16'hFFFF, 4'd0, 1'b0);
    step(4'hD, 16'h0001, 4'd0, 1'b0);
    step(4'hD, 16'h8000, 4'd0, 1'b0);
    step(4'hD, 16'h4000, 4'd0, 1'b1);
    // R5 load then immediate use (R4)
    step(4'h8, 16'h1234, 4'd5, 1'b1);
    step(4'h4, 16'hF0F0, 4'd0, 1'b1);
    step(4'h9, 16'hABCD, 4'd15, 1'b1);
    step(4'hC, 16'h8001, 4'd0, 1'b1);
    // R7 normalise load then use
    step(4'hE, 16'h00F0, 4'd0, 1'b0);
    step(4'h5, 16'h0003, 4'd0, 1'b1);
    step(4'hF, 16'hFFF3, 4'd0, 1'b1);
    step(4'h7, 16'h0001, 4'd0, 1'b1);
    // R1 R2 R3 amount extremes
    step(4'h2, 16'h8001, 4'd15, 1'b1);
    step(4'h3, 16'h8001, 4'd15, 1'b1);
    step(4'hA, 16'h8000, 4'd15, 1'b1);
    step(4'h1, 16'hFFFF, 4'd0, 1'b1);
    // R10 registers held by D and shifts
    step(4'hD, 16'h0100, 4'd9, 1'b0);
    step(4'hB, 16'h4000, 4'd3, 1'b1);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      rop = 4'($urandom_range(0, 15));
      rd  = 16'($urandom);
      if (n % 7 == 0) rd = (n % 2 == 0) ? 16'h0000 : 16'hFFFF;
      step(rop, rd, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
    end
    // R9 clear mid-run
    step(4'h8, 16'h0000, 4'd7, 1'b1);
    step(4'h9, 16'h0000, 4'd7, 1'b1);
    clr = 1'b1; instr = 4'h3; dataIn = 16'hBEEF; svIn = 4'd3;
    @(posedge clk);
    @(negedge clk);
    chk("R9 clear result", result, 16'h0000);
    clr = 1'b0;
    mOne = '0; mTwo = '0;
    step(4'h4, 16'h8421, 4'd9, 1'b1);
    step(4'h6, 16'h8421, 4'd9, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule